// File: doc/BRIEF.md
# Dual Compare Timer Register Frame

This block is a 32-bit register window onto a free-running 64-bit count. It shows the physical count, a virtual count equal to the physical count minus a 64-bit offset, the count frequency and the offset itself. It also holds two compare timers. The physical timer follows the physical count and the virtual timer follows the virtual count. Every 64-bit quantity is split into a low word and a high word at adjacent offsets.

A 6-bit gate word, driven from outside the frame, decides which register groups software may reach. A denied access reads back zero and its write is dropped.

Each timer has:
- a 64-bit compare value;
- a 32-bit relative view, which is the compare value minus the count;
- a control word with an enable bit, a mask bit and a read-only status bit.

A timer raises its interrupt line while it is enabled, not masked, and its count has reached the compare value. The count, offset and frequency arrive on input ports. The frame samples them and never changes them.

Top module: `tfr_frame`

## Requirements
- R1: Reads of byte offset 0x00 and 0x04 return the low and high words of the physical count. Reads of 0x08 and 0x0C return the low and high words of (physical count − offset), with 64-bit wraparound. Gate bit 0 allows the physical pair and gate bit 1 allows the virtual pair.
- R2: A read of 0x10 returns the frequency input when gate bit 2 is set. Reads of 0x18 and 0x1C return the offset low and high words when gate bit 3 is set.
- R3: Writes to 0x00–0x0C, 0x10, 0x18 and 0x1C change no readable value.
- R4: The word at 0x14 is always reachable. Only bits 0, 1, 8 and 9 store the written value. All its other bits read as zero.
- R5: The physical compare value sits at 0x20 (low) and 0x24 (high), and the virtual compare value at 0x30 and 0x34. Each word is writable and reads back what was written. Gate bit 5 allows the physical timer words (0x20–0x2C) and gate bit 4 allows the virtual timer words (0x30–0x3C).
- R6: A read of the relative word (0x28 physical, 0x38 virtual) returns the low 32 bits of (compare − count). A write there sets compare = count + the sign-extended 32-bit value, where count is the timer's own count in the cycle of the write.
- R7: In the control word (0x2C, 0x3C), bit 0 is enable and bit 1 is mask; both are writable. Bit 2 is a read-only status bit equal to enable AND (count ≥ compare, unsigned 64-bit). The virtual timer uses the virtual count.
- R8: Each interrupt output equals its timer's status AND NOT mask, evaluated from the current count.
- R9: An access whose gate bit is clear reads zero, and its write changes no register.
- R10: An offset that is not word aligned, or that is at or above 0x40, reads zero and its write has no effect.
- R11: Synchronous active-high reset clears both compare values, both control words, the 0x14 word and the read data.
- R12: Read data appears the cycle after the read request. It is zero in any cycle that follows no permitted read. A read and a write in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phys_count | input | 64 | Free-running physical count |
| virt_offset | input | 64 | Offset subtracted to form the virtual count |
| freq | input | 32 | Count frequency value |
| gate | input | 6 | Access gate word |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (8) | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| irq_phys | output | 1 | Physical timer interrupt |
| irq_virt | output | 1 | Virtual timer interrupt |

## Verification
The hardest situations to reach from the ports are the ones where the 64-bit compare runs into the ends of its range. Examples are a compare value whose high word is all ones, and a count pushed near its top so that the relative write wraps. A free-running count would take far too long to reach either. The bench therefore drives the count port directly and jumps it to chosen values between accesses, while a behavioural model follows every cycle. Gate retention is reached by programming the timers, dropping the gate to zero, issuing writes, then reopening the gate and reading the untouched values back.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

    localparam int WORD_W  = 32;
    localparam int CNT_W   = 2 * WORD_W;
    localparam int ACC_W   = 6;
    localparam int NUM_CH  = 2;
    localparam int NUM_SUB = 4;

    localparam int CH_PHYS = 0;
    localparam int CH_VIRT = 1;

    // gate bit positions
    localparam int GATE_PCNT = 0;
    localparam int GATE_VCNT = 1;
    localparam int GATE_FREQ = 2;
    localparam int GATE_VOFF = 3;
    localparam int GATE_VTMR = 4;
    localparam int GATE_PTMR = 5;

    // word slot inside a timer block
    localparam int SUB_CMP_LO = 0;
    localparam int SUB_CMP_HI = 1;
    localparam int SUB_REL    = 2;
    localparam int SUB_CTL    = 3;

    localparam logic [WORD_W-1:0] LP_KEEP = 32'h0000_0303;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PCNT_LO,
        SEL_PCNT_HI,
        SEL_VCNT_LO,
        SEL_VCNT_HI,
        SEL_FREQ,
        SEL_LPACC,
        SEL_VOFF_LO,
        SEL_VOFF_HI,
        SEL_TMR
    } sel_e;

    typedef struct packed {
        logic en;
        logic mask;
    } tmr_ctl_t;

    typedef struct packed {
        logic       hit;
        logic       permit;
        sel_e       sel;
        logic       ch;
        logic [1:0] sub;
    } dec_t;

    function automatic sel_e word_sel(logic [3:0] idx);
        case (idx)
            4'd0:    return SEL_PCNT_LO;
            4'd1:    return SEL_PCNT_HI;
            4'd2:    return SEL_VCNT_LO;
            4'd3:    return SEL_VCNT_HI;
            4'd4:    return SEL_FREQ;
            4'd5:    return SEL_LPACC;
            4'd6:    return SEL_VOFF_LO;
            4'd7:    return SEL_VOFF_HI;
            default: return SEL_TMR;
        endcase
    endfunction

    function automatic logic gate_ok(sel_e s, logic ch, logic [ACC_W-1:0] g);
        case (s)
            SEL_PCNT_LO, SEL_PCNT_HI: return g[GATE_PCNT];
            SEL_VCNT_LO, SEL_VCNT_HI: return g[GATE_VCNT];
            SEL_FREQ:                 return g[GATE_FREQ];
            SEL_VOFF_LO, SEL_VOFF_HI: return g[GATE_VOFF];
            SEL_LPACC:                return 1'b1;
            SEL_TMR:                  return ch ? g[GATE_VTMR] : g[GATE_PTMR];
            default:                  return 1'b0;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] sext_word(logic [WORD_W-1:0] w);
        return {{(CNT_W - WORD_W){w[WORD_W-1]}}, w};
    endfunction

endpackage

// File: rtl/tfr_decode.sv
module tfr_decode import tfr_pkg::*; #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ACC_W-1:0]  gate_i,
    output dec_t              dec_o
);

    localparam int WORD_LSB = 2;
    localparam int MAP_BITS = 6;

    logic       aligned;
    logic       in_window;
    logic [3:0] idx;

    assign aligned   = (addr_i[WORD_LSB-1:0] == '0);
    assign in_window = ((addr_i >> MAP_BITS) == '0);
    assign idx       = addr_i[MAP_BITS-1:WORD_LSB];

    always_comb begin
        dec_o     = '0;
        dec_o.sel = SEL_NONE;
        if (aligned && in_window) begin
            dec_o.hit    = 1'b1;
            dec_o.sel    = word_sel(idx);
            dec_o.ch     = idx[2];
            dec_o.sub    = idx[1:0];
            dec_o.permit = gate_ok(word_sel(idx), idx[2], gate_i);
        end
    end

endmodule

// File: rtl/tfr_channel.sv
module tfr_channel import tfr_pkg::*; (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   count_i,
    input  logic [NUM_SUB-1:0] we_i,
    input  logic [WORD_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]   cmp_o,
    output tmr_ctl_t           ctl_o,
    output logic               status_o,
    output logic [WORD_W-1:0]  rel_o,
    output logic               irq_o
);

    logic [CNT_W-1:0] cmp_q;
    tmr_ctl_t         ctl_q;
    logic [CNT_W-1:0] diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
            ctl_q <= '0;
        end else begin
            if (we_i[SUB_REL]) begin
                cmp_q <= count_i + sext_word(wdata_i);
            end else begin
                if (we_i[SUB_CMP_LO]) cmp_q[WORD_W-1:0]     <= wdata_i;
                if (we_i[SUB_CMP_HI]) cmp_q[CNT_W-1:WORD_W] <= wdata_i;
            end
            if (we_i[SUB_CTL]) begin
                ctl_q.en   <= wdata_i[0];
                ctl_q.mask <= wdata_i[1];
            end
        end
    end

    assign diff     = cmp_q - count_i;
    assign rel_o    = diff[WORD_W-1:0];
    assign status_o = ctl_q.en && (count_i >= cmp_q);
    assign irq_o    = status_o && !ctl_q.mask;
    assign cmp_o    = cmp_q;
    assign ctl_o    = ctl_q;

    AST_CMP_HELD: assert property (@(posedge clk) disable iff (rst) (we_i[SUB_CMP_LO] == 1'b0 && we_i[SUB_CMP_HI] == 1'b0 && we_i[SUB_REL] == 1'b0) |=> $stable(cmp_q)); // R9
    AST_REL_LOAD: assert property (@(posedge clk) disable iff (rst) we_i[SUB_REL] |=> cmp_q == $past(count_i) + {{(CNT_W - WORD_W){$past(wdata_i[WORD_W-1])}}, $past(wdata_i)}); // R6
    AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (cmp_q == '0 && ctl_q == '0)); // R11

endmodule

// File: rtl/tfr_frame.sv
module tfr_frame import tfr_pkg::*; #(
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   phys_count,
    input  logic [CNT_W-1:0]   virt_offset,
    input  logic [WORD_W-1:0]  freq,
    input  logic [ACC_W-1:0]   gate,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  rdata,
    output logic               irq_phys,
    output logic               irq_virt
);

    dec_t              dec;
    logic [CNT_W-1:0]  virt_count;
    logic [CNT_W-1:0]  ch_count  [NUM_CH];
    logic [CNT_W-1:0]  ch_cmp    [NUM_CH];
    tmr_ctl_t          ch_ctl    [NUM_CH];
    logic [WORD_W-1:0] ch_rel    [NUM_CH];
    logic [NUM_CH-1:0] ch_status;
    logic [NUM_CH-1:0] ch_irq;
    logic [WORD_W-1:0] lp_acc_q;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] rdata_q;

    tfr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (addr),
        .gate_i (gate),
        .dec_o  (dec)
    );

    assign virt_count        = phys_count - virt_offset;
    assign ch_count[CH_PHYS] = phys_count;
    assign ch_count[CH_VIRT] = virt_count;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [NUM_SUB-1:0] we;
        assign we = (wr_en && dec.permit && dec.sel == SEL_TMR && dec.ch == 1'(g))
                  ? ((NUM_SUB)'(1) << dec.sub) : '0;

        tfr_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .count_i  (ch_count[g]),
            .we_i     (we),
            .wdata_i  (wdata),
            .cmp_o    (ch_cmp[g]),
            .ctl_o    (ch_ctl[g]),
            .status_o (ch_status[g]),
            .rel_o    (ch_rel[g]),
            .irq_o    (ch_irq[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lp_acc_q <= '0;
        end else if (wr_en && dec.permit && dec.sel == SEL_LPACC) begin
            lp_acc_q <= wdata & LP_KEEP;
        end
    end

    always_comb begin
        rd_word = '0;
        case (dec.sel)
            SEL_PCNT_LO: rd_word = phys_count[WORD_W-1:0];
            SEL_PCNT_HI: rd_word = phys_count[CNT_W-1:WORD_W];
            SEL_VCNT_LO: rd_word = virt_count[WORD_W-1:0];
            SEL_VCNT_HI: rd_word = virt_count[CNT_W-1:WORD_W];
            SEL_FREQ:    rd_word = freq;
            SEL_LPACC:   rd_word = lp_acc_q;
            SEL_VOFF_LO: rd_word = virt_offset[WORD_W-1:0];
            SEL_VOFF_HI: rd_word = virt_offset[CNT_W-1:WORD_W];
            SEL_TMR: begin
                case (dec.sub)
                    2'd0:    rd_word = ch_cmp[dec.ch][WORD_W-1:0];
                    2'd1:    rd_word = ch_cmp[dec.ch][CNT_W-1:WORD_W];
                    2'd2:    rd_word = ch_rel[dec.ch];
                    default: rd_word = WORD_W'({ch_status[dec.ch], ch_ctl[dec.ch].mask, ch_ctl[dec.ch].en});
                endcase
            end
            default:     rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= (rd_en && dec.permit) ? rd_word : '0;
        end
    end

    assign rdata    = rdata_q;
    assign irq_phys = ch_irq[CH_PHYS];
    assign irq_virt = ch_irq[CH_VIRT];

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_en && !dec.hit) |=> rdata == '0); // R10
    AST_DENIED_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_en && !dec.permit) |=> rdata == '0); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !rd_en |=> rdata == '0); // R12
    AST_LP_BITS: assert property (@(posedge clk) disable iff (rst) (lp_acc_q & ~LP_KEEP) == '0); // R4

endmodule

// File: tb/tfr_frame_test.sv
module tfr_frame_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] pcount;
    logic [63:0] voff;
    logic [31:0] freq;
    logic [5:0]  gate;
    logic        wr_en;
    logic        rd_en;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq_phys;
    logic        irq_virt;

    int    compared   = 0;
    int    mismatched = 0;
    bit    done       = 1'b0;
    string req_tag    = "R11";
    logic [63:0] step_inc = 64'd1;

    // reference model state
    logic [63:0] m_cmp  [2];
    logic        m_en   [2];
    logic        m_mask [2];
    logic [31:0] m_lp;
    logic [31:0] m_rdata;
    logic [31:0] m_next;

    always #2ns clk = ~clk;

    tfr_frame #(.ADDR_W(8)) uut (
        .clk         (clk),
        .rst         (rst),
        .phys_count  (pcount),
        .virt_offset (voff),
        .freq        (freq),
        .gate        (gate),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .irq_phys    (irq_phys),
        .irq_virt    (irq_virt)
    );

    function automatic logic [63:0] m_count(int ch);
        if (ch == 0) return pcount;
        return pcount - voff;
    endfunction

    function automatic logic m_status(int ch);
        return m_en[ch] && (m_count(ch) >= m_cmp[ch]);
    endfunction

    function automatic logic m_allowed(logic [7:0] a);
        int w;
        if (a[1:0] != 2'b00 || a >= 8'h40) return 1'b0;
        w = int'(a) / 4;
        if (w < 2)   return gate[0];
        if (w < 4)   return gate[1];
        if (w == 4)  return gate[2];
        if (w == 5)  return 1'b1;
        if (w < 8)   return gate[3];
        if (w < 12)  return gate[5];
        return gate[4];
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        int w;
        int ch;
        int k;
        logic [63:0] d;
        w = int'(a) / 4;
        case (w)
            0: return pcount[31:0];
            1: return pcount[63:32];
            2: begin d = pcount - voff; return d[31:0]; end
            3: begin d = pcount - voff; return d[63:32]; end
            4: return freq;
            5: return m_lp;
            6: return voff[31:0];
            7: return voff[63:32];
            default: begin
                ch = (w >= 12) ? 1 : 0;
                k  = w % 4;
                if (k == 0) return m_cmp[ch][31:0];
                if (k == 1) return m_cmp[ch][63:32];
                if (k == 2) begin d = m_cmp[ch] - m_count(ch); return d[31:0]; end
                return {29'd0, m_status(ch), m_mask[ch], m_en[ch]};
            end
        endcase
    endfunction

    task automatic m_write(logic [7:0] a, logic [31:0] d);
        int w;
        int ch;
        int k;
        w = int'(a) / 4;
        if (w == 5) m_lp = d & 32'h0000_0303;
        if (w >= 8) begin
            ch = (w >= 12) ? 1 : 0;
            k  = w % 4;
            if (k == 0) m_cmp[ch][31:0]  = d;
            if (k == 1) m_cmp[ch][63:32] = d;
            if (k == 2) m_cmp[ch] = m_count(ch) + {{32{d[31]}}, d};
            if (k == 3) begin m_en[ch] = d[0]; m_mask[ch] = d[1]; end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_cmp[i] = 64'd0; m_en[i] = 1'b0; m_mask[i] = 1'b0;
            end
            m_lp    = 32'd0;
            m_rdata = 32'd0;
        end else begin
            m_next = 32'd0;
            if (rd_en && m_allowed(addr)) m_next = m_read(addr);
            if (wr_en && m_allowed(addr)) m_write(addr, wdata);
            m_rdata = m_next;
        end
    end

    task automatic chk(string what, string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk("rdata", req_tag, rdata, m_rdata);
        chk("irq_phys", "R8", {31'd0, irq_phys}, {31'd0, m_status(0) && !m_mask[0]});
        chk("irq_virt", "R8", {31'd0, irq_virt}, {31'd0, m_status(1) && !m_mask[1]});
        pcount = pcount + step_inc;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a);
        addr = a; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R12 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        pcount = 64'h0000_0002_FFFF_FFF0;
        voff   = 64'h0000_0001_0000_0005;
        freq   = 32'd50_000_000;
        gate   = 6'h3F;
        wr_en  = 1'b0;
        rd_en  = 1'b0;
        addr   = 8'h00;
        wdata  = 32'd0;

        // R11 reset state
        req_tag = "R11";
        repeat (3) tick();
        rst = 1'b0;
        rd(8'h20); rd(8'h24); rd(8'h2C); rd(8'h34); rd(8'h3C); rd(8'h14);

        // R1 counts, including the carry into the high word
        req_tag = "R1";
        for (int i = 0; i < 20; i++) begin
            rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);
        end

        // R2 frequency and offset
        req_tag = "R2";
        rd(8'h10); rd(8'h18); rd(8'h1C);

        // R3 read-only words
        req_tag = "R3";
        wr(8'h00, 32'hDEAD_BEEF); wr(8'h04, 32'h1111_1111); wr(8'h08, 32'h2222_2222);
        wr(8'h10, 32'h3333_3333); wr(8'h18, 32'h4444_4444); wr(8'h1C, 32'h5555_5555);
        rd(8'h10); rd(8'h18); rd(8'h1C); rd(8'h00); rd(8'h20); rd(8'h14);

        // R4 access word
        req_tag = "R4";
        wr(8'h14, 32'hFFFF_FFFF); rd(8'h14);
        wr(8'h14, 32'h0000_0102); rd(8'h14);

        // R5 compare words
        req_tag = "R5";
        wr(8'h20, 32'h1234_5678); wr(8'h24, 32'h9ABC_DEF0); rd(8'h20); rd(8'h24);
        wr(8'h30, 32'h0BAD_F00D); wr(8'h34, 32'h0000_0007); rd(8'h30); rd(8'h34);

        // R6 relative view
        req_tag = "R6";
        rd(8'h28); rd(8'h38);
        wr(8'h28, 32'd20); rd(8'h20); rd(8'h24); rd(8'h28);
        wr(8'h38, 32'hFFFF_FFF0); rd(8'h38); rd(8'h30); rd(8'h34);

        // R7 status rises as the count reaches compare
        req_tag = "R7";
        wr(8'h2C, 32'h0000_0001);
        repeat (25) rd(8'h2C);
        wr(8'h3C, 32'hFFFF_FFFD); rd(8'h3C);
        wr(8'h24, 32'hFFFF_FFFF); rd(8'h2C);
        pcount = 64'hFFFF_FFFF_FFFF_FF00;
        rd(8'h2C); rd(8'h28); rd(8'h3C);
        wr(8'h28, 32'h0000_0080); rd(8'h24); rd(8'h20);
        repeat (4) rd(8'h2C);
        pcount = 64'h0000_0010_0000_0000;

        // R8 mask hides the interrupt but not the status
        req_tag = "R8";
        wr(8'h28, 32'hFFFF_FFFF); rd(8'h2C);
        wr(8'h2C, 32'h0000_0003); rd(8'h2C);
        wr(8'h2C, 32'h0000_0001); rd(8'h2C);
        wr(8'h3C, 32'h0000_0003); rd(8'h3C);
        wr(8'h3C, 32'h0000_0001); rd(8'h3C);

        // R9 gate closed: reads zero, writes dropped
        req_tag = "R9";
        gate = 6'h00;
        rd(8'h00); rd(8'h0C); rd(8'h10); rd(8'h18); rd(8'h20); rd(8'h2C); rd(8'h3C); rd(8'h14);
        wr(8'h20, 32'h0); wr(8'h24, 32'h0); wr(8'h28, 32'h100);
        wr(8'h2C, 32'h0); wr(8'h3C, 32'h0); wr(8'h38, 32'h0); wr(8'h30, 32'h0);
        gate = 6'h10;
        rd(8'h2C); rd(8'h3C); rd(8'h08);
        wr(8'h20, 32'hAAAA_AAAA);
        gate = 6'h20;
        rd(8'h20); rd(8'h30);
        wr(8'h30, 32'h5555_5555);
        gate = 6'h3F;
        rd(8'h20); rd(8'h24); rd(8'h2C); rd(8'h30); rd(8'h3C);
        gate = 6'h05;
        rd(8'h00); rd(8'h08); rd(8'h10); rd(8'h18);
        gate = 6'h3F;

        // R10 unmapped and misaligned
        req_tag = "R10";
        wr(8'h40, 32'hFFFF_FFFF); wr(8'h22, 32'h0); wr(8'hFC, 32'h0); wr(8'h2D, 32'h0); wr(8'h55, 32'h3);
        rd(8'h40); rd(8'h22); rd(8'hFE); rd(8'h61);
        rd(8'h20); rd(8'h2C); rd(8'h14);

        // R12 latency, idle zero, read-before-write in one cycle
        req_tag = "R12";
        repeat (3) tick();
        addr = 8'h20; wdata = 32'h0F0F_0F0F; rd_en = 1'b1; wr_en = 1'b1;
        tick();
        rd_en = 1'b0; wr_en = 1'b0;
        tick();
        rd(8'h20);
        tick();

        summary();
        $finish;
    end

endmodule